// File: doc/BRIEF.md
# Hot-Swap Fault Register with Alert and Board-Select Handling

This block keeps the sticky fault record of a hot-swap controller. It has two 8-bit fault banks, a 16-bit alert-enable mask split over two bytes, and a 4-bit on-control register. The fault and power-bad logic raise per-bit set requests. These requests are levels: a request stays asserted while its fault is still present or while it is inside a cool-down period. Any bit that sees its request becomes one and stays one until something clears it. Four things can clear the banks: a bus write, a falling edge of the ON pin, an undervoltage-lockout reset, and a board insertion. A live set request always wins over any of these clears. Automatic retries elsewhere in the controller do not touch the banks.

The board-select input is active low. Low means a card is seated. High means the card is gone, and the switch-off output rises at once. Every change of the board-select level sets a change-of-state flag, which is bit 6 of bank B. An insertion clears every other fault bit. After the level has stayed low for a programmable number of cycles, the block samples the ON pin into the on-control bits. The sequence-mode input decides whether the sample goes into all four bits or into bit 0 only.

Writes arrive on a valid/ready port. The block never applies back-pressure: `wr_ready` is held high, and every cycle with `wr_valid` high is one accepted write. The bus protocol and the alert-response handshake are outside this block.

Top module: `hs_fault_regs`

## Requirements
- R1: After reset both fault banks, both mask bytes and the on-control bits are zero, `alert_n` is 1, and with `bdsel_n` held high `bdsel_level` and `sw_off` read 1.
- R2: A bit whose set request is high in a cycle reads 1 after that clock edge, whatever clear acts in the same cycle. Once its request drops the bit stays set until it is cleared.
- R3: An accepted write replaces the addressed register with `wr_data`, so zeros clear bits and ones set them. The addresses are: 0 fault bank A, 1 fault bank B, 2 mask for A, 3 mask for B, 4 on-control (bits 3:0). `wr_ready` is always 1.
- R4: A high-to-low transition of the synchronised ON pin clears both fault banks.
- R5: `uvlo_rst` high for one cycle clears both fault banks at that clock edge.
- R6: A high-to-low transition of synchronised board-select clears all fault bits except bank B bit 6, which is set. When `seq_mode` is 1 it also clears on-control bits 3:1.
- R7: Every transition of synchronised board-select sets bank B bit 6. `bdsel_level` shows the synchronised level. `sw_off` is 1 in every cycle in which that level is high, so it rises together with the level on removal.
- R8: When synchronised board-select has been low for CAPTURE_CYCLES clock edges, the synchronised ON level is copied into on-control bit 0 only (`seq_mode`=1) or into all four bits (`seq_mode`=0).
- R9: `alert_n` goes to 0 one cycle after any fault bit is 1 while its matching mask bit is 1. It is 1 otherwise, including whenever both masks are zero.
- R10: A change on `on_pin` or `bdsel_n` takes effect in the registers at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_rst | input | 1 | Undervoltage-lockout clear, synchronous, active high |
| set_a | input | 8 | Per-bit set requests for fault bank A |
| set_b | input | 8 | Per-bit set requests for fault bank B |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (constant 1) |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| on_pin | input | 1 | ON pin, asynchronous |
| bdsel_n | input | 1 | Board-select, active low, asynchronous, debounced externally |
| seq_mode | input | 1 | Sequence mode for insertion clear and capture |
| fault_a | output | 8 | Fault bank A contents |
| fault_b | output | 8 | Fault bank B contents |
| on_ctrl | output | 4 | On-control bits |
| bdsel_level | output | 1 | Synchronised board-select level |
| sw_off | output | 1 | Board removed, switches forced off |
| alert_n | output | 1 | Active-low alert |

## Verification
The assertions assume that set requests, `uvlo_rst`, `seq_mode` and the write port are synchronous to `clk`. They also assume that `on_pin` and `bdsel_n` may be asynchronous but stay stable long enough for the two synchronising flops to pass every level. The stimulus changes all inputs only on the falling clock edge. It holds each ON and board-select level for at least four cycles, and it keeps `bdsel_n` high through reset, so that no insertion is seen before the board is deliberately seated.

// File: rtl/hs_fault_pkg.sv
package hs_fault_pkg;
  localparam int FLT_W = 8;
  localparam int ON_W  = 4;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FLT_A  = 3'd0,
    ADDR_FLT_B  = 3'd1,
    ADDR_MASK_A = 3'd2,
    ADDR_MASK_B = 3'd3,
    ADDR_ONCTL  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/hs_pin_sync.sv
module hs_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic level_d
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= RST_VAL;
    else        level_d <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/hs_fault_bank.sv
module hs_fault_bank #(
  parameter int           W         = 8,
  parameter logic [W-1:0] KEEP_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_req,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr_all,
  input  logic         bd_fall,
  input  logic         bd_edge,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  // Lowest priority first: bus write, global clear, insertion clear,
  // change-of-state flag, then live set requests on top of all.
  always_comb begin
    nxt = wr_en ? wr_data : q;
    if (clr_all) nxt = '0;
    if (bd_fall) nxt = nxt & KEEP_MASK;
    if (bd_edge) nxt = nxt | KEEP_MASK;
    nxt = nxt | set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/hs_insert_ctrl.sv
module hs_insert_ctrl #(
  parameter int ON_W           = 4,
  parameter int CAPTURE_CYCLES = 10_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bd_level,
  input  logic            bd_fall,
  input  logic            on_level,
  input  logic            seq_mode,
  input  logic            wr_en,
  input  logic [ON_W-1:0] wr_data,
  output logic [ON_W-1:0] on_ctrl
);
  localparam int CNT_W = $clog2(CAPTURE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAPTURE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CAPTURE_CYCLES);

  logic [CNT_W-1:0] low_cnt;
  logic             capture;
  logic [ON_W-1:0]  nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (bd_level)       low_cnt <= '0;
    else if (low_cnt != CNT_SAT) low_cnt <= low_cnt + 1'b1;
  end

  assign capture = !bd_level && (low_cnt == CNT_LAST);

  always_comb begin
    nxt = wr_en ? wr_data : on_ctrl;
    if (bd_fall && seq_mode) nxt[ON_W-1:1] = '0;
    if (capture) begin
      if (seq_mode) nxt[0] = on_level;
      else          nxt    = {ON_W{on_level}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_ctrl <= '0;
    else        on_ctrl <= nxt;
  end
endmodule

// File: rtl/hs_alert_gen.sv
module hs_alert_gen #(
  parameter int W     = 8,
  parameter int BANKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BANKS*W-1:0] flt,
  input  logic [BANKS*W-1:0] msk,
  output logic               alert_n
);
  logic [BANKS-1:0] bank_hit;

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      assign bank_hit[b] = |(flt[b*W +: W] & msk[b*W +: W]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_n <= 1'b1;
    else        alert_n <= ~(|bank_hit);
  end
endmodule

// File: rtl/hs_fault_regs.sv
module hs_fault_regs
  import hs_fault_pkg::*;
#(
  parameter int FLT_W          = hs_fault_pkg::FLT_W,
  parameter int ON_W           = hs_fault_pkg::ON_W,
  parameter int COS_BIT        = 6,
  parameter int SYNC_STAGES    = 2,
  parameter int CAPTURE_CYCLES = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo_rst,
  input  logic [FLT_W-1:0]  set_a,
  input  logic [FLT_W-1:0]  set_b,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [FLT_W-1:0]  wr_data,
  input  logic              on_pin,
  input  logic              bdsel_n,
  input  logic              seq_mode,
  output logic [FLT_W-1:0]  fault_a,
  output logic [FLT_W-1:0]  fault_b,
  output logic [ON_W-1:0]   on_ctrl,
  output logic              bdsel_level,
  output logic              sw_off,
  output logic              alert_n
);
  localparam int NBANK = 2;
  localparam logic [FLT_W-1:0] COS_MASK = FLT_W'(1) << COS_BIT;

  logic wr_fire;
  logic on_lvl, on_lvl_d, on_fall;
  logic bd_lvl, bd_lvl_d, bd_fall, bd_rise, bd_edge;
  logic clr_all;
  logic [FLT_W-1:0] mask_a, mask_b;
  logic [FLT_W-1:0] flt_q   [NBANK];
  logic [FLT_W-1:0] set_arr [NBANK];
  logic [NBANK-1:0] flt_wr;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;

  hs_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_on_sync (
    .clk(clk), .rst_n(rst_n), .din(on_pin), .level(on_lvl), .level_d(on_lvl_d)
  );

  hs_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bd_sync (
    .clk(clk), .rst_n(rst_n), .din(bdsel_n), .level(bd_lvl), .level_d(bd_lvl_d)
  );

  assign on_fall = on_lvl_d & ~on_lvl;
  assign bd_fall = bd_lvl_d & ~bd_lvl;
  assign bd_rise = ~bd_lvl_d & bd_lvl;
  assign bd_edge = bd_fall | bd_rise;
  assign clr_all = uvlo_rst | on_fall;

  assign set_arr[0] = set_a;
  assign set_arr[1] = set_b;
  assign flt_wr[0]  = wr_fire && (wr_addr == ADDR_FLT_A);
  assign flt_wr[1]  = wr_fire && (wr_addr == ADDR_FLT_B);

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      hs_fault_bank #(
        .W(FLT_W),
        .KEEP_MASK((b == 1) ? COS_MASK : '0)
      ) u_bank (
        .clk(clk), .rst_n(rst_n), .set_req(set_arr[b]),
        .wr_en(flt_wr[b]), .wr_data(wr_data), .clr_all(clr_all),
        .bd_fall(bd_fall), .bd_edge(bd_edge), .q(flt_q[b])
      );
    end
  endgenerate

  assign fault_a = flt_q[0];
  assign fault_b = flt_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a <= '0;
      mask_b <= '0;
    end else if (wr_fire) begin
      if (wr_addr == ADDR_MASK_A) mask_a <= wr_data;
      if (wr_addr == ADDR_MASK_B) mask_b <= wr_data;
    end
  end

  hs_insert_ctrl #(.ON_W(ON_W), .CAPTURE_CYCLES(CAPTURE_CYCLES)) u_insert (
    .clk(clk), .rst_n(rst_n), .bd_level(bd_lvl), .bd_fall(bd_fall),
    .on_level(on_lvl), .seq_mode(seq_mode),
    .wr_en(wr_fire && (wr_addr == ADDR_ONCTL)),
    .wr_data(wr_data[ON_W-1:0]), .on_ctrl(on_ctrl)
  );

  hs_alert_gen #(.W(FLT_W), .BANKS(NBANK)) u_alert (
    .clk(clk), .rst_n(rst_n),
    .flt({fault_b, fault_a}), .msk({mask_b, mask_a}),
    .alert_n(alert_n)
  );

  assign bdsel_level = bd_lvl;
  assign sw_off      = bd_lvl;
endmodule

// File: rtl/hs_fault_regs_chk.sv
module hs_fault_regs_chk #(
  parameter int FLT_W   = 8,
  parameter int COS_BIT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uvlo_rst,
  input logic [FLT_W-1:0] set_a,
  input logic [FLT_W-1:0] set_b,
  input logic [FLT_W-1:0] fault_a,
  input logic [FLT_W-1:0] fault_b,
  input logic [FLT_W-1:0] mask_a,
  input logic [FLT_W-1:0] mask_b,
  input logic             alert_n,
  input logic             sw_off,
  input logic             on_fall,
  input logic             bd_fall,
  input logic             bd_rise,
  input logic             bd_edge
);
  assert_set_wins_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_a != '0) |=> ((fault_a & $past(set_a)) == $past(set_a)));

  assert_set_wins_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_b != '0) |=> ((fault_b & $past(set_b)) == $past(set_b)));

  assert_on_fall_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (on_fall && set_a == '0) |=> (fault_a == '0));

  assert_uvlo_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_rst && set_a == '0) |=> (fault_a == '0));

  assert_insert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_fall && set_a == '0) |=> (fault_a == '0));

  assert_cos_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bd_edge |=> fault_b[COS_BIT]);

  assert_removal_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bd_rise |-> sw_off);

  assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_a == '0 && mask_b == '0) |=> alert_n);
endmodule

bind hs_fault_regs hs_fault_regs_chk #(.FLT_W(FLT_W), .COS_BIT(COS_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo_rst(uvlo_rst), .set_a(set_a), .set_b(set_b),
  .fault_a(fault_a), .fault_b(fault_b), .mask_a(mask_a), .mask_b(mask_b),
  .alert_n(alert_n), .sw_off(sw_off), .on_fall(on_fall), .bd_fall(bd_fall),
  .bd_rise(bd_rise), .bd_edge(bd_edge)
);

// File: tb/tb_hs_fault_regs.sv
module tb_hs_fault_regs;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uvlo_rst = 1'b0;
  logic [7:0] set_a = '0, set_b = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       on_pin = 1'b0, bdsel_n = 1'b1, seq_mode = 1'b0;
  logic [7:0] fault_a, fault_b;
  logic [3:0] on_ctrl;
  logic       bdsel_level, sw_off, alert_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_fault_regs #(.CAPTURE_CYCLES(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .uvlo_rst(uvlo_rst), .set_a(set_a), .set_b(set_b),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .on_pin(on_pin), .bdsel_n(bdsel_n), .seq_mode(seq_mode),
    .fault_a(fault_a), .fault_b(fault_b), .on_ctrl(on_ctrl),
    .bdsel_level(bdsel_level), .sw_off(sw_off), .alert_n(alert_n)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] sa;
    logic [7:0] sb;
    logic [7:0] ea;
    logic [7:0] eb;
  } vec_t;

  // R2 / R3 table: one clock per row, banks checked after the edge
  localparam vec_t VEC [8] = '{
    '{1'b0, 3'd0, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00},
    '{1'b0, 3'd0, 8'h00, 8'h00, 8'h10, 8'h01, 8'h10},
    '{1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h10},
    '{1'b1, 3'd1, 8'h00, 8'h00, 8'h10, 8'h00, 8'h10},
    '{1'b1, 3'd0, 8'h81, 8'h00, 8'h00, 8'h81, 8'h10},
    '{1'b1, 3'd1, 8'h00, 8'h00, 8'h00, 8'h81, 8'h00},
    '{1'b1, 3'd0, 8'h80, 8'h04, 8'h00, 8'h84, 8'h00},
    '{1'b1, 3'd2, 8'h04, 8'h00, 8'h00, 8'h84, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_set_a(input logic [7:0] v);
    set_a = v;
    @(negedge clk);
    set_a = '0;
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    // R1 reset state
    chk("R1 fault_a", fault_a, 8'h00);
    chk("R1 fault_b", fault_b, 8'h00);
    chk("R1 on_ctrl", {4'h0, on_ctrl}, 8'h00);
    chk("R1 alert_n", {7'h0, alert_n}, 8'h01);
    chk("R1 bdsel_level", {7'h0, bdsel_level}, 8'h01);
    chk("R1 sw_off", {7'h0, sw_off}, 8'h01);
    chk("R3 wr_ready", {7'h0, wr_ready}, 8'h01);

    // Table walk: R2 set priority, R3 write semantics
    for (int i = 0; i < 8; i++) begin
      wr_valid = VEC[i].wr; wr_addr = VEC[i].addr; wr_data = VEC[i].wdata;
      set_a = VEC[i].sa; set_b = VEC[i].sb;
      @(negedge clk);
      chk($sformatf("R2/R3 row %0d fault_a", i), fault_a, VEC[i].ea);
      chk($sformatf("R2/R3 row %0d fault_b", i), fault_b, VEC[i].eb);
      wr_valid = 1'b0; set_a = '0; set_b = '0;
    end

    // R9 alert with mask A bit 2 enabled and fault_a = 84
    cycles(2);
    chk("R9 alert asserted", {7'h0, alert_n}, 8'h00);
    bus_write(3'd2, 8'h00);
    cycles(2);
    chk("R9 alert released", {7'h0, alert_n}, 8'h01);

    // R4 / R10 ON falling edge clears, set request survives (R2)
    set_a = 8'h02;
    on_pin = 1'b1;
    cycles(5);
    chk("R2 set ORed", fault_a, 8'h86);
    on_pin = 1'b0;
    cycles(2);
    chk("R10 no clear before third edge", fault_a, 8'h86);
    cycles(1);
    chk("R4 ON fall clear keeps live set", fault_a, 8'h02);
    chk("R4 ON fall bank B", fault_b, 8'h00);
    set_a = '0;
    cycles(2);
    chk("R2 sticky after request drops", fault_a, 8'h02);

    // R5 undervoltage-lockout clear
    uvlo_rst = 1'b1;
    @(negedge clk);
    uvlo_rst = 1'b0;
    chk("R5 uvlo clear", fault_a, 8'h00);

    // R9 bank B with mask B
    bus_write(3'd1, 8'h20);
    chk("R3 write sets B", fault_b, 8'h20);
    bus_write(3'd3, 8'h20);
    cycles(2);
    chk("R9 alert via mask B", {7'h0, alert_n}, 8'h00);
    bus_write(3'd3, 8'h00);
    cycles(2);
    chk("R9 mask B cleared", {7'h0, alert_n}, 8'h01);

    // R6 / R8 insertion with seq_mode = 1
    pulse_set_a(8'h10);
    chk("R2 set A", fault_a, 8'h10);
    on_pin = 1'b1;
    cycles(5);
    bus_write(3'd4, 8'h0E);
    chk("R3 on_ctrl write", {4'h0, on_ctrl}, 8'h0E);
    seq_mode = 1'b1;
    bdsel_n = 1'b0;
    cycles(4);
    chk("R6 insert clears A", fault_a, 8'h00);
    chk("R6 insert leaves only COS in B", fault_b, 8'h40);
    chk("R6 seq clears on_ctrl 3:1", {4'h0, on_ctrl}, 8'h00);
    chk("R7 level low", {7'h0, bdsel_level}, 8'h00);
    chk("R7 sw_off low", {7'h0, sw_off}, 8'h00);
    cycles(LIMIT - 4);
    chk("R8 no capture before limit", {4'h0, on_ctrl}, 8'h00);
    cycles(3);
    chk("R8 seq capture bit 0", {4'h0, on_ctrl}, 8'h01);

    // R7 removal
    pulse_set_a(8'h08);
    bus_write(3'd1, 8'h00);
    chk("R3 COS bit write clear", fault_b, 8'h00);
    bdsel_n = 1'b1;
    cycles(4);
    chk("R7 sw_off on removal", {7'h0, sw_off}, 8'h01);
    chk("R7 level high", {7'h0, bdsel_level}, 8'h01);
    chk("R7 removal sets COS", fault_b, 8'h40);
    chk("R7 removal keeps A", fault_a, 8'h08);
    chk("R7 removal keeps on_ctrl", {4'h0, on_ctrl}, 8'h01);

    // R8 insertion with seq_mode = 0
    seq_mode = 1'b0;
    bdsel_n = 1'b0;
    cycles(LIMIT + 3);
    chk("R6 second insert clears A", fault_a, 8'h00);
    chk("R8 all-bit capture", {4'h0, on_ctrl}, 8'h0F);

    // R4 ON fall clears COS in bank B
    on_pin = 1'b0;
    cycles(4);
    chk("R4 ON fall clears B", fault_b, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule